// File: doc/BRIEF.md
# Triple-Redundant Up/Down Counter with Feedback Voting

This block is a small synchronous up/down counter with load and clear, built as three independent redundancy domains. Each domain holds its own copy of the count register, receives its own copy of every control input, and computes its next count from a 2-of-3 bitwise majority of all three current registers. Voting sits only in this feedback loop. When one domain's register takes a bit flip, the other two outvote it and the flipped domain is rewritten with the correct value at the next clock edge. Simultaneous corruption of two domains is outside what the block corrects.

All three per-domain counts are exposed, together with a single voted count and a per-domain mismatch flag for observation. A fault-injection port XORs a mask into one chosen domain's register at a clock edge. A testbench uses it to model an upset.

Top module: `tmr_counter`

## Requirements
- R1: When a domain's synchronous clear input is high at a clock edge, that domain's register becomes zero. Clear takes priority over load and count. Clearing a single domain leaves the voted count unchanged, and that domain realigns at the next edge once its clear is low.
- R2: When a domain's load input is high and clear is low, that domain's register takes its own copy of the load value at the edge. Load takes priority over counting.
- R3: With enable high and no clear or load, a domain's register becomes the voted count plus one when its direction bit is 0, or minus one when it is 1. The count wraps modulo 2^WIDTH in both directions.
- R4: With enable, load and clear all low, a domain's register takes the voted count, so the count holds.
- R5: A fault injected into one domain is repaired by the next edge. At that edge all three registers again hold the value the majority would have reached.
- R6: mismatch bit d is high exactly while domain d's register differs from the bitwise majority of the three registers. It is all zero after an edge at which every domain saw identical inputs and no injection took place.
- R7: The voted count is the bitwise 2-of-3 majority of the three domain counts.
- R8: A control input that differs in one domain only does not change the voted count. A disagreement shared by two domains carries the third domain with it at the next edge.
- R9: When the injection enable is high, the injection mask is XORed into the register of the domain selected by the domain index (0, 1 or 2) at that edge. Index 3 selects no domain, and the injection then has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all domains |
| rstTri | input | 3 | Synchronous clear, one bit per domain, active high |
| enTri | input | 3 | Count enable, one bit per domain |
| dirTri | input | 3 | Count direction per domain: 0 counts up, 1 counts down |
| loadTri | input | 3 | Load strobe per domain |
| loadValTri | input | 3*WIDTH | Load value; domain d occupies bits [d*WIDTH +: WIDTH] |
| injEn | input | 1 | Fault-injection enable |
| injDomain | input | 2 | Domain that receives the injection (3 selects none) |
| injMask | input | WIDTH | Bits to flip in the selected domain's register |
| cntTri | output | 3*WIDTH | Per-domain counts; domain d at bits [d*WIDTH +: WIDTH] |
| cntVoted | output | WIDTH | Bitwise majority of the three counts |
| mismatch | output | 3 | Per-domain disagreement with the majority |

## Verification
The counter is driven through clear, load, count up and count down, including wrap at all-ones and at zero. These patterns separate the priority order and the arithmetic from the voting. A single-bit upset is then injected into every bit of every domain while the counter advances, which shows that each domain's feedback voter repairs its own register. Inputs that disagree in one domain and in two domains show the difference between outvoting a lone domain and letting a majority carry the odd one along. An injection aimed at index 3 confirms that an unselected injection changes nothing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_DOM = 3;

  typedef struct packed {
    logic clr;
    logic load;
    logic inc;
    logic dec;
    logic flip;
  } domStrobe_t;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic [NUM_DOM-1:0] rstTri,
  input  logic [NUM_DOM-1:0] enTri,
  input  logic [NUM_DOM-1:0] dirTri,
  input  logic [NUM_DOM-1:0] loadTri,
  input  logic               injEn,
  input  logic [1:0]         injDomain,
  output domStrobe_t [NUM_DOM-1:0] strobes
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    // priority: clear, then load, then count
    always_comb begin
      strobes[d].clr  = rstTri[d];
      strobes[d].load = !rstTri[d] && loadTri[d];
      strobes[d].inc  = !rstTri[d] && !loadTri[d] && enTri[d] && !dirTri[d];
      strobes[d].dec  = !rstTri[d] && !loadTri[d] && enTri[d] && dirTri[d];
      strobes[d].flip = injEn && (injDomain == 2'(d));
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  domStrobe_t [NUM_DOM-1:0] strobes,
  input  logic [NUM_DOM*WIDTH-1:0] loadValTri,
  input  logic [WIDTH-1:0]         injMask,
  output logic [NUM_DOM*WIDTH-1:0] cntTri,
  output logic [WIDTH-1:0]         cntVoted,
  output logic [NUM_DOM-1:0]       mismatch
);
  logic [WIDTH-1:0] stateQ [NUM_DOM];

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic [WIDTH-1:0] fbVoted;
    logic [WIDTH-1:0] nextCnt;

    // each domain owns its feedback voter
    tmr_voter #(.W(WIDTH)) u_fbVote (
      .a(stateQ[0]), .b(stateQ[1]), .c(stateQ[2]), .y(fbVoted)
    );

    always_comb begin
      if (strobes[d].clr)       nextCnt = '0;
      else if (strobes[d].load) nextCnt = loadValTri[d*WIDTH +: WIDTH];
      else if (strobes[d].inc)  nextCnt = fbVoted + WIDTH'(1);
      else if (strobes[d].dec)  nextCnt = fbVoted - WIDTH'(1);
      else                      nextCnt = fbVoted;
    end

    always_ff @(posedge clk) begin
      stateQ[d] <= nextCnt ^ (strobes[d].flip ? injMask : '0);
    end

    assign mismatch[d]              = (stateQ[d] != fbVoted);
    assign cntTri[d*WIDTH +: WIDTH] = stateQ[d];
  end

  // single-rail view for observation only
  tmr_voter #(.W(WIDTH)) u_outVote (
    .a(stateQ[0]), .b(stateQ[1]), .c(stateQ[2]), .y(cntVoted)
  );
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic [2:0]               rstTri,
  input  logic [2:0]               enTri,
  input  logic [2:0]               dirTri,
  input  logic [2:0]               loadTri,
  input  logic [3*WIDTH-1:0]       loadValTri,
  input  logic                     injEn,
  input  logic [1:0]               injDomain,
  input  logic [WIDTH-1:0]         injMask,
  output logic [3*WIDTH-1:0]       cntTri,
  output logic [WIDTH-1:0]         cntVoted,
  output logic [2:0]               mismatch
);
  domStrobe_t [NUM_DOM-1:0] strobes;

  tmr_ctrl u_ctrl (
    .rstTri(rstTri), .enTri(enTri), .dirTri(dirTri), .loadTri(loadTri),
    .injEn(injEn), .injDomain(injDomain), .strobes(strobes)
  );

  tmr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .strobes(strobes), .loadValTri(loadValTri), .injMask(injMask),
    .cntTri(cntTri), .cntVoted(cntVoted), .mismatch(mismatch)
  );
endmodule

// File: rtl/tmr_counter_chk.sv
module tmr_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic [2:0]         rstTri,
  input logic [2:0]         enTri,
  input logic [2:0]         dirTri,
  input logic [2:0]         loadTri,
  input logic [3*WIDTH-1:0] loadValTri,
  input logic               injEn,
  input logic [1:0]         injDomain,
  input logic [WIDTH-1:0]   injMask,
  input logic [3*WIDTH-1:0] cntTri,
  input logic [WIDTH-1:0]   cntVoted,
  input logic [2:0]         mismatch
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | (&rstTri);

  logic inAgree;
  logic allEqual;
  assign inAgree = (rstTri == {3{rstTri[0]}}) && (enTri == {3{enTri[0]}}) &&
                   (dirTri == {3{dirTri[0]}}) && (loadTri == {3{loadTri[0]}}) &&
                   (loadValTri[WIDTH-1:0] == loadValTri[WIDTH +: WIDTH]) &&
                   (loadValTri[WIDTH-1:0] == loadValTri[2*WIDTH +: WIDTH]);
  assign allEqual = (cntTri[WIDTH-1:0] == cntTri[WIDTH +: WIDTH]) &&
                    (cntTri[WIDTH-1:0] == cntTri[2*WIDTH +: WIDTH]);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
    (&rstTri) |=> (cntVoted == '0)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!armed)
    (inAgree && !rstTri[0] && loadTri[0]) |=> (cntVoted == $past(loadValTri[WIDTH-1:0]))); // R2
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!armed)
    (inAgree && rstTri == 3'b000 && loadTri == 3'b000 && enTri == 3'b111 && dirTri == 3'b000)
    |=> (cntVoted == $past(cntVoted) + WIDTH'(1))); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!armed)
    (inAgree && rstTri == 3'b000 && loadTri == 3'b000 && enTri == 3'b000)
    |=> $stable(cntVoted)); // R4
  AST_REPAIR_ALIGN: assert property (@(posedge clk) disable iff (!armed)
    (inAgree && !injEn) |=> allEqual); // R5
  AST_NO_MISMATCH: assert property (@(posedge clk) disable iff (!armed)
    (inAgree && !injEn) |=> (mismatch == 3'b000)); // R6
  AST_UNSELECTED_INJ: assert property (@(posedge clk) disable iff (!armed)
    (inAgree && injEn && injDomain == 2'd3) |=> allEqual); // R9
endmodule

bind tmr_counter tmr_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstTri(rstTri), .enTri(enTri), .dirTri(dirTri), .loadTri(loadTri),
  .loadValTri(loadValTri), .injEn(injEn), .injDomain(injDomain), .injMask(injMask),
  .cntTri(cntTri), .cntVoted(cntVoted), .mismatch(mismatch)
);

// File: tb/tmr_counter_bench.sv
module tmr_counter_bench;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [2:0] rstTri = 3'b111, enTri = '0, dirTri = '0, loadTri = '0;
  logic [3*W-1:0] loadValTri = '0;
  logic injEn = 1'b0;
  logic [1:0] injDomain = '0;
  logic [W-1:0] injMask = '0;
  logic [3*W-1:0] cntTri;
  logic [W-1:0] cntVoted;
  logic [2:0] mismatch;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_counter #(.WIDTH(W)) u_tmr_counter (
    .clk(clk), .rstTri(rstTri), .enTri(enTri), .dirTri(dirTri), .loadTri(loadTri),
    .loadValTri(loadValTri), .injEn(injEn), .injDomain(injDomain), .injMask(injMask),
    .cntTri(cntTri), .cntVoted(cntVoted), .mismatch(mismatch)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] r, input logic [2:0] e, input logic [2:0] dr,
                       input logic [2:0] l, input logic [W-1:0] v);
    rstTri = r; enTri = e; dirTri = dr; loadTri = l; loadValTri = {3{v}};
  endtask

  // one edge, then compare every domain, the vote and the flags
  task automatic stepCheck(input string req, input logic [W-1:0] e0,
                           input logic [W-1:0] e1, input logic [W-1:0] e2);
    logic [W-1:0] maj;
    @(posedge clk); #1;
    maj = (e0 & e1) | (e0 & e2) | (e1 & e2);
    chk({req, " dom0"}, int'(cntTri[0 +: W]), int'(e0));
    chk({req, " dom1"}, int'(cntTri[W +: W]), int'(e1));
    chk({req, " dom2"}, int'(cntTri[2*W +: W]), int'(e2));
    chk({req, " R7 voted"}, int'(cntVoted), int'(maj));
    chk({req, " R6 mismatch"}, int'(mismatch),
        int'({e2 != maj, e1 != maj, e0 != maj}));
  endtask

  task automatic testReset();
    drive(3'b111, 3'b111, 3'b000, 3'b111, 8'h55);
    stepCheck("R1 clear priority", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic testCount();
    drive(3'b000, 3'b111, 3'b000, 3'b000, 8'h00);
    for (int i = 1; i <= 5; i++) stepCheck("R3 up", W'(i), W'(i), W'(i));
    drive(3'b000, 3'b111, 3'b111, 3'b000, 8'h00);
    stepCheck("R3 down", 8'h04, 8'h04, 8'h04);
    drive(3'b000, 3'b111, 3'b000, 3'b111, 8'hFF);
    stepCheck("R2 load over count", 8'hFF, 8'hFF, 8'hFF);
    drive(3'b000, 3'b111, 3'b000, 3'b000, 8'h00);
    stepCheck("R3 wrap up", 8'h00, 8'h00, 8'h00);
    drive(3'b000, 3'b111, 3'b111, 3'b000, 8'h00);
    stepCheck("R3 wrap down", 8'hFF, 8'hFF, 8'hFF);
  endtask

  task automatic testHold();
    drive(3'b000, 3'b000, 3'b000, 3'b000, 8'h00);
    stepCheck("R4 hold", 8'hFF, 8'hFF, 8'hFF);
    stepCheck("R4 hold again", 8'hFF, 8'hFF, 8'hFF);
  endtask

  task automatic testInject();
    for (int d = 0; d < 3; d++) begin
      for (int b = 0; b < W; b++) begin
        logic [W-1:0] m;
        logic [W-1:0] e [3];
        m = W'(1) << b;
        drive(3'b000, 3'b000, 3'b000, 3'b111, 8'h3C);
        stepCheck("R2 load", 8'h3C, 8'h3C, 8'h3C);
        drive(3'b000, 3'b111, 3'b000, 3'b000, 8'h00);
        injEn = 1'b1; injDomain = 2'(d); injMask = m;
        for (int k = 0; k < 3; k++) e[k] = (k == d) ? (8'h3D ^ m) : 8'h3D;
        stepCheck("R9 inject", e[0], e[1], e[2]);
        injEn = 1'b0;
        stepCheck("R5 repaired", 8'h3E, 8'h3E, 8'h3E);
      end
    end
  endtask

  task automatic testNoDomain();
    drive(3'b000, 3'b000, 3'b000, 3'b000, 8'h00);
    injEn = 1'b1; injDomain = 2'd3; injMask = 8'hFF;
    stepCheck("R9 index 3 ignored", 8'h3E, 8'h3E, 8'h3E);
    injEn = 1'b0;
  endtask

  task automatic testDisagree();
    drive(3'b000, 3'b001, 3'b000, 3'b000, 8'h00);
    stepCheck("R8 lone enable", 8'h3F, 8'h3E, 8'h3E);
    drive(3'b000, 3'b000, 3'b000, 3'b000, 8'h00);
    stepCheck("R8 realign", 8'h3E, 8'h3E, 8'h3E);
    drive(3'b000, 3'b000, 3'b000, 3'b110, 8'h77);
    stepCheck("R8 two-domain load", 8'h3E, 8'h77, 8'h77);
    drive(3'b000, 3'b000, 3'b000, 3'b000, 8'h00);
    stepCheck("R8 carried along", 8'h77, 8'h77, 8'h77);
    drive(3'b100, 3'b000, 3'b000, 3'b000, 8'h00);
    stepCheck("R1 lone clear", 8'h77, 8'h77, 8'h00);
    drive(3'b000, 3'b000, 3'b000, 3'b000, 8'h00);
    stepCheck("R1 lone clear realign", 8'h77, 8'h77, 8'h77);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    testReset();
    testCount();
    testHold();
    testInject();
    testNoDomain();
    testDisagree();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule